// File: doc/BRIEF.md
# TDM Serial Input Deframer

This block takes a single time-division-multiplexed serial line whose frames repeat every 125 µs. It turns the bit stream into 8-bit channel bytes. A master clock that runs at twice the fastest line rate drives the block. An active-low frame pulse marks each frame start. Each finished byte comes out for one clock cycle on a parallel port, together with its channel number and a valid strobe. The frame always spans 2048 master cycles.

The line rate is set per stream. The first bit of the frame can be pushed later by a whole number of bit periods. The frame is cut into four equal quadrants, and each quadrant can be told to force the least significant bit of its channels to one before the byte leaves the block. The rate, delay and quadrant settings are all captured at a frame boundary. After any change the block waits for channel 0 before it emits data again.

Top module: `tdm_deframer`

## Requirements
- R1: `rate_i` selects the bit period in master cycles and the channels per frame: 0 gives 8 cycles and 32 channels, 1 gives 4 cycles and 64 channels, 2 gives 2 cycles and 128 channels, and the unused code 3 acts like 0. A frame is always 2048 master cycles.
- R2: A rising clock edge on which `fp_ni` is low, after it was high at the previous edge, is a frame boundary. The master cycle that follows this edge is cycle 0 of the frame.
- R3: Bits arrive most significant first. With zero delay, bit 7 of channel 0 fills the first bit period of the frame. Each bit is sampled in the last master cycle of its bit period.
- R4: `dly_i` (0 to 7) moves the whole frame later by that many bit periods. Bits pushed past the frame end fall into the next frame period. So when the delay is nonzero, the last channel of a frame before a configuration switch is never emitted.
- R5: `ch_valid_o` is high for exactly one master cycle. That cycle follows the edge that samples the final bit of a channel. `ch_data_o` holds the byte with the first received bit in bit 7, and `ch_num_o` holds the channel number.
- R6: While the configuration stays the same, emitted channel numbers run 0, 1, … up to the channel count minus 1 and then wrap to 0, with no channel skipped or repeated across frame boundaries.
- R7: The quadrant of channel c is c divided by a quarter of the channel count. When bit q of `quad_en_i` is set, bit 0 of every byte in quadrant q is output as 1. Otherwise the byte passes unchanged.
- R8: The block reads `rate_i`, `dly_i` and `quad_en_i` only at a frame boundary. A change between boundaries has no effect on the bytes until the next boundary.
- R9: No byte is emitted before the first frame boundary. After a boundary that loads a different configuration, no byte is emitted until channel 0 has been fully received again, and channel 0 is the first byte out.
- R10: While reset is active, and in the cycle after it is released, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, twice the fastest line rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fp_ni | input | 1 | Frame pulse, active low |
| sd_i | input | 1 | Serial line data |
| rate_i | input | 2 | Line rate select |
| dly_i | input | 3 | Whole-bit input delay |
| quad_en_i | input | 4 | Per-quadrant bit-0 force enables |
| ch_data_o | output | 8 | Received channel byte |
| ch_num_o | output | 7 | Channel number of the byte |
| ch_valid_o | output | 1 | One-cycle byte strobe |

## Verification
On every cycle the assertions check four things: the strobe is a single-cycle pulse, the channel number is within the active channel count, channel numbers follow each other in order, and bit 0 is forced inside enabled quadrants. They also check that the captured configuration changes only at a boundary and that nothing comes out before the first boundary. Only the bench scenarios can show that the byte values, the effect of the delay, the channel lost at a delayed configuration switch, the restart on channel 0, and the effect of a mid-frame input change all match, because each of these needs the stream that was actually driven onto the line.

// File: rtl/tdm_deframer_pkg.sv
package tdm_deframer_pkg;
  localparam int DLY_W  = 3;
  localparam int QUAD_N = 4;

  typedef enum logic [1:0] {
    RATE_2M  = 2'd0,
    RATE_4M  = 2'd1,
    RATE_8M  = 2'd2,
    RATE_RSV = 2'd3
  } rate_e;

  typedef struct packed {
    rate_e             rate;
    logic [DLY_W-1:0]  dly;
    logic [QUAD_N-1:0] qen;
  } cfg_t;

  // log2 of master cycles per bit
  function automatic logic [1:0] rate_shift(rate_e r);
    case (r)
      RATE_8M: rate_shift = 2'd1;
      RATE_4M: rate_shift = 2'd2;
      default: rate_shift = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/tdm_frame_ctl.sv
module tdm_frame_ctl
  import tdm_deframer_pkg::*;
#(
  parameter int FRM_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_ni,
  input  cfg_t             cfg_i,
  output logic             bnd_o,
  output logic             restart_o,
  output logic             lock_o,
  output cfg_t             cfg_o,
  output logic [FRM_W-1:0] fcnt_o
);
  logic fp_q;

  assign bnd_o     = fp_q & ~fp_ni;
  assign restart_o = bnd_o & (cfg_i != cfg_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fp_q   <= 1'b1;
      fcnt_o <= '0;
      cfg_o  <= '0;
      lock_o <= 1'b0;
    end else begin
      fp_q <= fp_ni;
      if (bnd_o) begin
        fcnt_o <= '0;
        cfg_o  <= cfg_i;
        lock_o <= 1'b1;
      end else begin
        fcnt_o <= fcnt_o + FRM_W'(1);
      end
    end
  end
endmodule

// File: rtl/tdm_bit_pos.sv
module tdm_bit_pos
  import tdm_deframer_pkg::*;
#(
  parameter int FRM_W = 11,
  parameter int BIT_W = 3,
  parameter int CH_W  = FRM_W - BIT_W - 1
) (
  input  logic [FRM_W-1:0] fcnt_i,
  input  cfg_t             cfg_i,
  output logic             smp_o,
  output logic [BIT_W-1:0] bit_o,
  output logic [CH_W-1:0]  ch_o,
  output logic [1:0]       quad_o
);
  localparam int Q_BASE = FRM_W - BIT_W - 2;

  logic [1:0]       shf;
  logic [3:0]       qsh;
  logic [FRM_W-1:0] off, pos, mask;
  logic [FRM_W-2:0] bidx;

  always_comb begin
    shf    = rate_shift(cfg_i.rate);
    off    = FRM_W'(cfg_i.dly) << shf;
    // delay wraps the stream position back into the previous frame period
    pos    = fcnt_i - off;
    mask   = (FRM_W'(1) << shf) - FRM_W'(1);
    smp_o  = (pos & mask) == mask;
    bidx   = (FRM_W-1)'(pos >> shf);
    bit_o  = bidx[BIT_W-1:0];
    ch_o   = bidx[BIT_W +: CH_W];
    qsh    = 4'(Q_BASE) - {2'b00, shf};
    quad_o = 2'(ch_o >> qsh);
  end
endmodule

// File: rtl/tdm_byte_asm.sv
module tdm_byte_asm #(
  parameter int CH_BITS = 8,
  parameter int CH_W    = 7,
  parameter int QUAD_N  = 4,
  localparam int BIT_W  = $clog2(CH_BITS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sd_i,
  input  logic               smp_i,
  input  logic [BIT_W-1:0]   bit_i,
  input  logic [CH_W-1:0]    ch_i,
  input  logic [1:0]         quad_i,
  input  logic [QUAD_N-1:0]  qen_i,
  input  logic               lock_i,
  input  logic               restart_i,
  output logic [CH_BITS-1:0] data_o,
  output logic [CH_W-1:0]    ch_o,
  output logic               valid_o
);
  logic [CH_BITS-2:0] sh_q;
  logic               run_q;
  logic               last_bit, first_bit;

  assign last_bit  = bit_i == BIT_W'(CH_BITS - 1);
  assign first_bit = (bit_i == '0) && (ch_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      run_q   <= 1'b0;
      data_o  <= '0;
      ch_o    <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (smp_i) begin
        sh_q <= {sh_q[CH_BITS-3:0], sd_i};
        if (last_bit && run_q) begin
          data_o  <= {sh_q, sd_i | qen_i[quad_i]};
          ch_o    <= ch_i;
          valid_o <= 1'b1;
        end
      end
      // new settings: hold output until channel 0 starts again
      if (restart_i)                            run_q <= 1'b0;
      else if (smp_i && first_bit && lock_i)    run_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tdm_deframer.sv
module tdm_deframer
  import tdm_deframer_pkg::*;
#(
  parameter int  FRM_W   = 11,
  parameter int  CH_BITS = 8,
  localparam int BIT_W   = $clog2(CH_BITS),
  localparam int CH_W    = FRM_W - BIT_W - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fp_ni,
  input  logic               sd_i,
  input  logic [1:0]         rate_i,
  input  logic [DLY_W-1:0]   dly_i,
  input  logic [QUAD_N-1:0]  quad_en_i,
  output logic [CH_BITS-1:0] ch_data_o,
  output logic [CH_W-1:0]    ch_num_o,
  output logic               ch_valid_o
);
  cfg_t             cfg_in, act_cfg;
  logic             bnd, restart, lock, smp;
  logic [FRM_W-1:0] fcnt;
  logic [BIT_W-1:0] bit_idx;
  logic [CH_W-1:0]  ch_idx;
  logic [1:0]       quad;

  assign cfg_in = '{rate: rate_e'(rate_i), dly: dly_i, qen: quad_en_i};

  tdm_frame_ctl #(.FRM_W(FRM_W)) u_ctl (
    .clk_i, .rst_ni, .fp_ni,
    .cfg_i     (cfg_in),
    .bnd_o     (bnd),
    .restart_o (restart),
    .lock_o    (lock),
    .cfg_o     (act_cfg),
    .fcnt_o    (fcnt)
  );

  tdm_bit_pos #(.FRM_W(FRM_W), .BIT_W(BIT_W), .CH_W(CH_W)) u_pos (
    .fcnt_i (fcnt),
    .cfg_i  (act_cfg),
    .smp_o  (smp),
    .bit_o  (bit_idx),
    .ch_o   (ch_idx),
    .quad_o (quad)
  );

  tdm_byte_asm #(.CH_BITS(CH_BITS), .CH_W(CH_W), .QUAD_N(QUAD_N)) u_asm (
    .clk_i, .rst_ni, .sd_i,
    .smp_i     (smp),
    .bit_i     (bit_idx),
    .ch_i      (ch_idx),
    .quad_i    (quad),
    .qen_i     (act_cfg.qen),
    .lock_i    (lock),
    .restart_i (restart),
    .data_o    (ch_data_o),
    .ch_o      (ch_num_o),
    .valid_o   (ch_valid_o)
  );
endmodule

// File: rtl/tdm_deframer_chk.sv
module tdm_deframer_chk
  import tdm_deframer_pkg::*;
#(
  parameter int FRM_W   = 11,
  parameter int CH_BITS = 8,
  parameter int CH_W    = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ch_valid_o,
  input logic [CH_W-1:0]    ch_num_o,
  input logic [CH_BITS-1:0] ch_data_o,
  input cfg_t               act_cfg,
  input logic               bnd,
  input logic               lock
);
  localparam int BIT_W = $clog2(CH_BITS);

  logic [CH_W:0]   nch;
  logic [1:0]      q;
  logic [CH_W-1:0] prev_ch;
  logic            seen;

  always_comb begin
    nch = (CH_W+1)'(1) << (FRM_W - BIT_W - int'(rate_shift(act_cfg.rate)));
    q   = 2'(ch_num_o >> (FRM_W - BIT_W - 2 - int'(rate_shift(act_cfg.rate))));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_ch <= '0;
      seen    <= 1'b0;
    end else if (ch_valid_o) begin
      prev_ch <= ch_num_o;
      seen    <= 1'b1;
    end
  end

  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_valid_o |=> !ch_valid_o);

  // R1
  ch_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_valid_o |-> ({1'b0, ch_num_o} < nch));

  // R7
  quad_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_valid_o && act_cfg.qen[q]) |-> ch_data_o[0]);

  // R6
  ch_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_valid_o && seen && ch_num_o != '0) |-> (ch_num_o == prev_ch + CH_W'(1)));

  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd |=> $stable(act_cfg));

  // R9
  no_early_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock |-> !ch_valid_o);
endmodule

bind tdm_deframer tdm_deframer_chk #(.FRM_W(FRM_W), .CH_BITS(CH_BITS), .CH_W(CH_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ch_valid_o (ch_valid_o),
  .ch_num_o   (ch_num_o),
  .ch_data_o  (ch_data_o),
  .act_cfg    (act_cfg),
  .bnd        (bnd),
  .lock       (lock)
);

// File: tb/tdm_deframer_bench.sv
module tdm_deframer_bench;
  localparam int FRAME = 2048;
  localparam int NS    = 10;
  localparam int FPS   = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni, fp_ni, sd_i;
  logic [1:0] rate_i;
  logic [2:0] dly_i;
  logic [3:0] quad_en_i;
  logic [7:0] ch_data_o;
  logic [6:0] ch_num_o;
  logic       ch_valid_o;

  always #10 clk_i = ~clk_i;

  tdm_deframer u_tdm_deframer (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  int scn_rate [NS] = '{0, 0, 0, 1, 1, 1, 2, 2, 2, 3};
  int scn_dly  [NS] = '{0, 3, 7, 0, 5, 7, 0, 1, 7, 2};
  int scn_q    [NS] = '{0, 15, 5, 10, 1, 0, 8, 6, 15, 3};

  int b_div, b_nch, b_dly, b_q;
  int kf, mon_ch, mon_frm, n_bytes;

  function automatic logic [7:0] pat(int fr, int c);
    return 8'((fr * 53 + c * 29 + 17) ^ (c * 7));
  endfunction

  function automatic int div_of(int r);
    return (r == 2) ? 2 : (r == 1) ? 4 : 8;
  endfunction

  function automatic logic sd_bit(int t);
    int p, fr, c, b;
    logic [7:0] v;
    p  = t - b_dly * b_div;
    fr = kf;
    if (p < 0) begin p += FRAME; fr = kf - 1; end
    c = p / (8 * b_div);
    b = (p / b_div) % 8;
    v = pat(fr, c);
    return v[7 - b];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R3 R5 R6 R7 R8: byte value and channel order against the driven stream
  task automatic check_out();
    logic [7:0] exp;
    if (ch_valid_o) begin
      exp = pat(mon_frm, mon_ch);
      if (b_q[mon_ch / (b_nch / 4)]) exp[0] = 1'b1;
      check(int'(ch_num_o) == mon_ch, "R6 R9 channel", int'(ch_num_o), mon_ch);
      check(ch_data_o == exp, "R3 R5 R7 R8 data", int'(ch_data_o), int'(exp));
      n_bytes++;
      mon_ch++;
      if (mon_ch == b_nch) begin mon_ch = 0; mon_frm++; end
    end
  endtask

  // R1 R2 R4: bytes per scenario, last channel lost when delayed
  task automatic count_check();
    int exp;
    exp = FPS * b_nch - ((b_dly != 0) ? 1 : 0);
    check(n_bytes == exp, "R1 R2 R4 byte count", n_bytes, exp);
  endtask

  task automatic load_bench_cfg(int s);
    b_div = div_of(scn_rate[s]);
    b_nch = FRAME / (8 * b_div);
    b_dly = scn_dly[s];
    b_q   = scn_q[s];
  endtask

  task automatic drive_inputs(int s);
    rate_i    = 2'(scn_rate[s]);
    dly_i     = 3'(scn_dly[s]);
    quad_en_i = 4'(scn_q[s]);
  endtask

  initial begin
    rst_ni = 1'b0; fp_ni = 1'b1; sd_i = 1'b0;
    rate_i = '0; dly_i = '0; quad_en_i = '0;
    repeat (3) @(negedge clk_i);
    // R10
    check(ch_valid_o == 1'b0, "R10 valid in reset", int'(ch_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(ch_valid_o == 1'b0, "R10 valid", int'(ch_valid_o), 0);
    check(ch_data_o == 8'd0, "R10 data", int'(ch_data_o), 0);
    check(ch_num_o == 7'd0, "R10 channel", int'(ch_num_o), 0);

    drive_inputs(0);
    load_bench_cfg(0);
    kf = 0; mon_ch = 0; mon_frm = 0; n_bytes = 0;
    // R9: an idle stretch before the first pulse yields no bytes
    repeat (300) begin
      @(negedge clk_i);
      check(ch_valid_o == 1'b0, "R9 no byte before boundary", int'(ch_valid_o), 0);
    end
    @(negedge clk_i);
    fp_ni = 1'b0;

    for (int s = 0; s < NS; s++) begin
      for (int f = 0; f < FPS; f++) begin
        for (int t = 0; t < FRAME; t++) begin
          @(negedge clk_i);
          check_out();
          if (t == 0 && f == 0 && s > 0) begin
            count_check();
            load_bench_cfg(s);
            mon_ch = 0; mon_frm = kf; n_bytes = 0;
          end
          // R8: inputs change mid-frame, bytes follow the old settings
          if (t == FRAME / 2 && f == FPS - 1 && s < NS - 1) drive_inputs(s + 1);
          fp_ni = (t == FRAME - 1) ? 1'b0 : 1'b1;
          sd_i  = sd_bit(t);
        end
        kf++;
      end
    end
    @(negedge clk_i);
    check_out();
    count_check();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule